// File: doc/BRIEF.md
# Serial Loss-of-Signal Detector with Squelch

The block watches a recovered serial stream, one bit per clock, and raises a loss-of-signal alarm when the line stops toggling. It compares each bit with the one before it to find transitions. A run counter measures the stretch since the last transition and sets the internal alarm once that stretch is too long. A sliding record of the most recent transition flags clears the alarm again. Setting and clearing use different rules, so the alarm does not chatter on a marginal line.

Two inputs shape the status the block reports. An optical module can force loss through an active-low flag. A disable input stops the internal alarm from reaching the output, although the detector keeps tracking the line. While the combined status is high, the parallel data word passing through the block is forced to zero. That word is registered once on its way through, so downstream logic never sees stale data during an outage.

Top module: `serial_los_detect`

## Requirements
- R1: A transition is a clock in which `ser_i` differs from the bit sampled at the previous edge; the history bit resets to 0. The internal alarm sets at the edge where the count of consecutive bits without a transition reaches RUN_LIM+1 (129 by default).
- R2: While set, the internal alarm clears at the edge where the number of transitions among the last WIN bits (128 by default), that edge's bit included, reaches CLR_MIN (16 by default).
- R3: Between those two events the internal alarm holds its value. Sparse transitions that never fill the window to CLR_MIN keep it set.
- R4: With `det_dis_i` high the internal alarm does not drive `los_o`. The detector keeps updating its state, and `los_o` follows the alarm again as soon as `det_dis_i` goes low.
- R5: A low level on `ext_los_ni` drives `los_o` high in the same cycle, whatever the internal state is.
- R6: `los_o` equals (internal alarm AND NOT `det_dis_i`) OR NOT `ext_los_ni`.
- R7: Whenever `los_o` is high, `par_o` is all zeros in that same cycle.
- R8: Whenever `los_o` is low, `par_o` equals `par_i` as sampled at the previous clock edge.
- R9: After reset the internal alarm is set, the window and the run counter are empty, and the data register holds zero. `los_o` is therefore high until enough transitions arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Recovered serial bit |
| det_dis_i | input | 1 | High: internal alarm masked from the output |
| ext_los_ni | input | 1 | External loss flag, active low |
| par_i | input | PAR_W | Parallel word from the deserializer |
| par_o | output | PAR_W | Parallel word, zeroed during loss |
| los_o | output | 1 | Combined loss-of-signal status |

## Verification
The bench aims at the exact edges of both thresholds. It sends runs of 128 and 129 identical bits, and bursts of 15 and 16 transitions. A counter that is off by one sets or clears the alarm one bit early or late. Evenly spaced transitions test the sliding window: one every 10 bits must keep the alarm set, while one every 8 bits must clear it, so a window that forgets old flags wrongly, or never forgets them, shows up. The bench also toggles the disable and external flags across alarm changes, to catch status that is latched or inverted, and a squelch that lags `los_o` by a cycle.

// File: rtl/serial_los_pkg.sv
package serial_los_pkg;
  function automatic int cnt_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sld_run_ctr.sv
module sld_run_ctr #(
  parameter int RUN_LIM = 128,
  localparam int RW = serial_los_pkg::cnt_width(RUN_LIM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trans_i,
  output logic [RW-1:0] run_d_o,
  output logic [RW-1:0] run_q_o
);
  localparam logic [RW-1:0] SAT = RW'(RUN_LIM + 1);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_d;

  always_comb begin
    if (trans_i)          run_d = '0;
    else if (run_q == SAT) run_d = run_q;
    else                  run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else         run_q <= run_d;
  end

  assign run_d_o = run_d;
  assign run_q_o = run_q;

  assert_run_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_i |=> run_q == '0);
  assert_run_saturates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= SAT);
endmodule

// File: rtl/sld_window.sv
module sld_window #(
  parameter int WIN = 128,
  localparam int CW = serial_los_pkg::cnt_width(WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trans_i,
  output logic [CW-1:0] cnt_d_o
);
  logic [WIN-1:0] win_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_d;

  // count follows the flag entering minus the flag leaving
  assign cnt_d = cnt_q + CW'(trans_i) - CW'(win_q[WIN-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else begin
      win_q <= {win_q[WIN-2:0], trans_i};
      cnt_q <= cnt_d;
    end
  end

  assign cnt_d_o = cnt_d;

  assert_win_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CW'($countones(win_q)));
endmodule

// File: rtl/sld_squelch.sv
module sld_squelch #(
  parameter int PAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             los_i,
  input  logic [PAR_W-1:0] par_i,
  output logic [PAR_W-1:0] par_o
);
  logic [PAR_W-1:0] par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= '0;
    else         par_q <= par_i;
  end

  assign par_o = los_i ? '0 : par_q;
endmodule

// File: rtl/serial_los_detect.sv
module serial_los_detect #(
  parameter int RUN_LIM = 128,
  parameter int WIN     = 128,
  parameter int CLR_MIN = 16,
  parameter int PAR_W   = 8,
  localparam int RW = serial_los_pkg::cnt_width(RUN_LIM + 1),
  localparam int CW = serial_los_pkg::cnt_width(WIN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             det_dis_i,
  input  logic             ext_los_ni,
  input  logic [PAR_W-1:0] par_i,
  output logic [PAR_W-1:0] par_o,
  output logic             los_o
);
  localparam logic [RW-1:0] RUN_LIM_W = RW'(RUN_LIM);
  localparam logic [CW-1:0] CLR_MIN_W = CW'(CLR_MIN);

  logic          prev_q;
  logic          trans;
  logic [RW-1:0] run_d;
  logic [RW-1:0] run_q;
  logic [CW-1:0] cnt_d;
  logic          alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= ser_i;
  end

  assign trans = ser_i ^ prev_q;

  sld_run_ctr #(.RUN_LIM(RUN_LIM)) u_run (
    .clk_i, .rst_ni, .trans_i(trans), .run_d_o(run_d), .run_q_o(run_q)
  );

  sld_window #(.WIN(WIN)) u_win (
    .clk_i, .rst_ni, .trans_i(trans), .cnt_d_o(cnt_d)
  );

  // set and clear use separate criteria (hysteresis)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             alarm_q <= 1'b1;
    else if (alarm_q && cnt_d >= CLR_MIN_W)  alarm_q <= 1'b0;
    else if (!alarm_q && run_d > RUN_LIM_W)  alarm_q <= 1'b1;
  end

  assign los_o = (alarm_q & ~det_dis_i) | ~ext_los_ni;

  sld_squelch #(.PAR_W(PAR_W)) u_sq (
    .clk_i, .rst_ni, .los_i(los_o), .par_i, .par_o
  );

  assert_long_run_alarms_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q > RUN_LIM_W |-> alarm_q);
  assert_clear_needs_edges_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_q) |-> run_q < RUN_LIM_W);
  assert_ext_forces_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_los_ni |-> par_o == '0);
endmodule

// File: tb/sim_serial_los_detect.sv
module sim_serial_los_detect;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ser_i = 1'b0;
  logic          det_dis_i = 1'b0;
  logic          ext_los_ni = 1'b1;
  logic [PW-1:0] par_i = '0;
  logic [PW-1:0] par_o;
  logic          los_o;

  int checks = 0;
  int errors = 0;

  // reference state
  int  wq[$];
  int  m_prev, m_run, m_alarm;
  logic [PW-1:0] m_par;
  logic cur_bit;

  always #5 clk = ~clk;

  serial_los_detect u0 (
    .clk_i(clk), .rst_ni, .ser_i, .det_dis_i, .ext_los_ni,
    .par_i, .par_o, .los_o
  );

  task automatic model_reset();
    wq.delete();
    for (int i = 0; i < 128; i++) wq.push_back(0);
    m_prev = 0; m_run = 0; m_alarm = 1; m_par = '0;
  endtask

  function automatic int win_sum();
    int s = 0;
    foreach (wq[i]) s += wq[i];
    return s;
  endfunction

  task automatic check(input string tag, input logic exp_los);
    logic [PW-1:0] exp_par;
    exp_par = exp_los ? '0 : m_par;
    checks++;
    if (los_o !== exp_los) begin
      errors++;
      $display("FAIL %s los_o actual=%0b expected=%0b t=%0t", tag, los_o, exp_los, $time);
    end
    checks++;
    if (par_o !== exp_par) begin
      errors++;
      $display("FAIL %s par_o actual=%0h expected=%0h t=%0t",
               exp_los ? "R7" : "R8", par_o, exp_par, $time);
    end
  endtask

  // drive one bit, step a clock, compare at the falling edge
  task automatic step(input string tag, input logic b, input logic dis,
                      input logic extn, input logic [PW-1:0] p);
    int t;
    ser_i = b; det_dis_i = dis; ext_los_ni = extn; par_i = p;
    @(posedge clk);
    t = (int'(b) != m_prev) ? 1 : 0;
    m_prev = int'(b);
    wq.push_back(t);
    void'(wq.pop_front());
    m_run = t ? 0 : ((m_run < 129) ? m_run + 1 : 129);
    if (m_alarm == 1 && win_sum() >= 16) m_alarm = 0;
    else if (m_alarm == 0 && m_run > 128) m_alarm = 1;
    m_par = p;
    @(negedge clk);
    check(tag, ((m_alarm == 1) && !dis) || !extn);
    cur_bit = b;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; ser_i = 1'b0; par_i = '0; det_dis_i = 1'b0; ext_los_ni = 1'b1;
    model_reset();
    cur_bit = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    check("R9", 1'b1);
  endtask

  task automatic toggles(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, ~cur_bit, 1'b0, 1'b1, 8'($urandom));
  endtask

  task automatic hold(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, cur_bit, 1'b0, 1'b1, 8'($urandom));
  endtask

  initial begin
    do_reset();
    // R2 boundary: 15 transitions keep alarm, 16th clears
    toggles("R2", 15);
    checks++; if (los_o !== 1'b1) begin errors++; $display("FAIL R2 after 15 los_o actual=%0b expected=1", los_o); end
    toggles("R2", 1);
    checks++; if (los_o !== 1'b0) begin errors++; $display("FAIL R2 after 16 los_o actual=%0b expected=0", los_o); end
    // R1 boundary: 128 idle bits hold, 129th sets
    hold("R1", 128);
    checks++; if (los_o !== 1'b0) begin errors++; $display("FAIL R1 after 128 los_o actual=%0b expected=0", los_o); end
    hold("R1", 1);
    checks++; if (los_o !== 1'b1) begin errors++; $display("FAIL R1 after 129 los_o actual=%0b expected=1", los_o); end
    // R3: one transition every 10 bits never reaches the clear count
    for (int k = 0; k < 30; k++) begin toggles("R3", 1); hold("R3", 9); end
    checks++; if (los_o !== 1'b1) begin errors++; $display("FAIL R3 sparse los_o actual=%0b expected=1", los_o); end
    // R2 sliding window: one every 8 bits fills it
    for (int k = 0; k < 20; k++) begin toggles("R2", 1); hold("R2", 7); end
    checks++; if (los_o !== 1'b0) begin errors++; $display("FAIL R2 spaced los_o actual=%0b expected=0", los_o); end
    // R4: disable masks alarm while detector keeps running
    for (int i = 0; i < 140; i++) step("R4", cur_bit, 1'b1, 1'b1, 8'($urandom));
    checks++; if (los_o !== 1'b0) begin errors++; $display("FAIL R4 masked los_o actual=%0b expected=0", los_o); end
    step("R4", cur_bit, 1'b0, 1'b1, 8'hA5);
    checks++; if (los_o !== 1'b1) begin errors++; $display("FAIL R4 unmasked los_o actual=%0b expected=1", los_o); end
    // R5/R6: external flag forces loss with alarm clear
    toggles("R6", 20);
    for (int i = 0; i < 10; i++) step("R5", ~cur_bit, 1'b0, 1'b0, 8'($urandom));
    for (int i = 0; i < 10; i++) step("R6", ~cur_bit, 1'b1, 1'b0, 8'($urandom));
    for (int i = 0; i < 10; i++) step("R6", ~cur_bit, 1'b1, 1'b1, 8'($urandom));
    // mixed random traffic with random flags
    for (int i = 0; i < 1500; i++) begin
      logic b;
      b = ($urandom_range(0, 9) < 1) ? ~cur_bit : cur_bit;
      if (i % 300 < 150) b = ($urandom_range(0, 1) == 1) ? ~cur_bit : cur_bit;
      step("R6", b, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) != 0), 8'($urandom));
    end
    // reset mid-run returns to alarmed state
    do_reset();
    toggles("R9", 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule